// File: doc/BRIEF.md
# Segmented Virtual Address Translator

The block turns a 32-bit CPU virtual address into a physical address and a cacheability attribute. The three most significant address bits choose how the address is treated. Two windows are unmapped: one cached and one uncached. Both reach a flat physical space whose size is set by a parameter. Every other address is looked up in an associative table of translation entries that software loads. Each entry covers one page, and the page size is set per entry, from 4 KB to 16 MB in steps of four.

A lookup is requested with `req_i` and answered one cycle later on `rsp_o`. When no entry matches a mapped address, the block raises `miss_o` and leaves the table unchanged. Software must load an entry through the write port and retry. If the matching entry is marked not valid, the block raises `invalid_o`. A store to a clean page raises `modify_o`.

Top module: `vat_top`

## Requirements
- R1: `rsp_o` is high exactly in the cycle after a cycle with `req_i` high. `miss_o`, `invalid_o`, `modify_o` and `range_err_o` are low whenever `rsp_o` is low.
- R2: When `va_i[31:29]` is 3'b101, the access is unmapped and uncached. `pa_o` is `{3'b000, va_i[28:0]}`, and `mapped_o` and `cached_o` are low.
- R3: When `va_i[31:29]` is 3'b100, the access is unmapped and cached. `pa_o` is `{3'b000, va_i[28:0]}`, `cached_o` is high and `mapped_o` is low.
- R4: For an unmapped access, `range_err_o` is high when `va_i[28:0]` is at or above `FLAT_BYTES` (default 8 MB). It is never high for a mapped access.
- R5: Every other segment value is mapped. If no table entry matches, `miss_o` is high, `pa_o` is zero and the table stays unchanged.
- R6: An entry matches when its 20-bit page tag equals `va_i[31:12]` with the lowest 2*size tag bits ignored, and either its global bit is set or its 8-bit ID equals `asid_i`.
- R7: On a hit, `pa_o` takes the frame number shifted left by 12, with the lowest 12+2*size bits replaced by the same bits of `va_i`. `cached_o` follows the entry's cacheable bit. The size codes 0 to 6 stand for 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB.
- R8: When several entries match, the entry with the lowest index supplies the result.
- R9: A match on an entry whose valid bit is clear raises `invalid_o`, with `miss_o` low and `pa_o` zero. At most one of `miss_o`, `invalid_o` and `modify_o` is high at a time.
- R10: A store (`store_i` high) that hits a valid entry with its dirty bit clear raises `modify_o` and still returns the translated `pa_o`. A load to the same entry does not raise it.
- R11: A cycle with `wr_en_i` high replaces entry `wr_idx_i` with the write fields, and lookups requested from the next cycle on see the new entry. Reset clears every field of every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| store_i | input | 1 | Request is a store |
| asid_i | input | 8 | Current address-space ID |
| wr_en_i | input | 1 | Table entry write strobe |
| wr_idx_i | input | 5 | Entry index to write |
| wr_vpn_i | input | 20 | Virtual page tag |
| wr_size_i | input | 3 | Page size code |
| wr_asid_i | input | 8 | Entry address-space ID |
| wr_global_i | input | 1 | Entry matches any ID |
| wr_pfn_i | input | 20 | Physical frame number |
| wr_valid_i | input | 1 | Entry valid bit |
| wr_dirty_i | input | 1 | Entry writable (dirty) bit |
| wr_cache_i | input | 1 | Entry cacheable bit |
| rsp_o | output | 1 | Lookup result valid |
| pa_o | output | 32 | Physical address |
| cached_o | output | 1 | Access is cacheable |
| mapped_o | output | 1 | Address went through the table |
| range_err_o | output | 1 | Unmapped address beyond flat space |
| miss_o | output | 1 | No matching entry |
| invalid_o | output | 1 | Matching entry not valid |
| modify_o | output | 1 | Store to clean page |

## Verification
A corrupted table entry or a wrong match mask shows up on the very next response. The result is then a false miss, a hit on the wrong entry, or a physical address whose offset boundary sits at the wrong bit. Page sizes are therefore exercised at more than one size code, and each is checked just inside and just outside the page. A broken priority pick shows up only when entries overlap, so two matching entries with different frames are loaded. A stale write shows up only when an entry is rewritten and looked up again straight away.

// File: rtl/vat_pkg.sv
package vat_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;
  localparam int SZ_W   = 3;
  localparam int PG_SH  = 12;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [SZ_W-1:0]   sz;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn;
    logic              vld;
    logic              dirty;
    logic              cache;
  } ent_t;
endpackage

// File: rtl/vat_seg_dec.sv
module vat_seg_dec #(
  parameter int unsigned FLAT_BYTES = 8 * 1024 * 1024
) (
  input  logic [31:0] va_i,
  output logic        mapped_o,
  output logic        cached_o,
  output logic        range_err_o,
  output logic [31:0] flat_pa_o
);
  logic unmapped;
  assign unmapped    = (va_i[31:29] == 3'b100) || (va_i[31:29] == 3'b101);
  assign mapped_o    = !unmapped;
  assign cached_o    = (va_i[31:29] == 3'b100);
  assign flat_pa_o   = {3'b000, va_i[28:0]};
  assign range_err_o = unmapped && (flat_pa_o >= FLAT_BYTES);
endmodule

// File: rtl/vat_ent_match.sv
module vat_ent_match
  import vat_pkg::*;
(
  input  ent_t              ent_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o
);
  logic [VPN_W-1:0] keep;
  // tag bits below the page boundary are don't-care
  assign keep  = ~((VPN_W'(1) << (2 * ent_i.sz)) - VPN_W'(1));
  assign hit_o = ((ent_i.vpn & keep) == (vpn_i & keep)) &&
                 (ent_i.glob || (ent_i.asid == asid_i));
endmodule

// File: rtl/vat_prio.sv
module vat_prio #(
  parameter int N     = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) idx_o = IDX_W'(i);
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/vat_top.sv
module vat_top
  import vat_pkg::*;
#(
  parameter int          N_ENT      = 32,
  parameter int unsigned FLAT_BYTES = 8 * 1024 * 1024,
  localparam int         IDX_W      = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       va_i,
  input  logic              store_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic              wr_cache_i,
  output logic              rsp_o,
  output logic [31:0]       pa_o,
  output logic              cached_o,
  output logic              mapped_o,
  output logic              range_err_o,
  output logic              miss_o,
  output logic              invalid_o,
  output logic              modify_o
);
  ent_t tbl [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (wr_en_i) begin
      tbl[wr_idx_i] <= '{vpn: wr_vpn_i, sz: wr_size_i, asid: wr_asid_i,
                         glob: wr_global_i, pfn: wr_pfn_i, vld: wr_valid_i,
                         dirty: wr_dirty_i, cache: wr_cache_i};
    end
  end

  logic        seg_mapped, seg_cached, seg_range;
  logic [31:0] flat_pa;

  vat_seg_dec #(.FLAT_BYTES(FLAT_BYTES)) u_seg (
    .va_i        (va_i),
    .mapped_o    (seg_mapped),
    .cached_o    (seg_cached),
    .range_err_o (seg_range),
    .flat_pa_o   (flat_pa)
  );

  logic [N_ENT-1:0] hits;
  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    vat_ent_match u_m (
      .ent_i  (tbl[g]),
      .vpn_i  (va_i[31:PG_SH]),
      .asid_i (asid_i),
      .hit_o  (hits[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  vat_prio #(.N(N_ENT)) u_prio (
    .hit_i (hits),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  ent_t        sel;
  logic [31:0] off_m, map_pa;
  logic        n_miss, n_inv, n_mod;
  logic [31:0] n_pa;
  logic        n_cached;

  always_comb begin
    sel    = tbl[hit_idx];
    off_m  = (32'd1 << (PG_SH + 2 * int'(sel.sz))) - 32'd1;
    map_pa = ({sel.pfn, 12'h000} & ~off_m) | (va_i & off_m);
    n_miss = seg_mapped && !any_hit;
    n_inv  = seg_mapped && any_hit && !sel.vld;
    n_mod  = seg_mapped && any_hit && sel.vld && store_i && !sel.dirty;
    if (!seg_mapped) begin
      n_pa     = flat_pa;
      n_cached = seg_cached;
    end else if (n_miss || n_inv) begin
      n_pa     = '0;
      n_cached = 1'b0;
    end else begin
      n_pa     = map_pa;
      n_cached = sel.cache;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_o       <= 1'b0;
      pa_o        <= '0;
      cached_o    <= 1'b0;
      mapped_o    <= 1'b0;
      range_err_o <= 1'b0;
      miss_o      <= 1'b0;
      invalid_o   <= 1'b0;
      modify_o    <= 1'b0;
    end else begin
      rsp_o       <= req_i;
      pa_o        <= req_i ? n_pa : '0;
      cached_o    <= req_i && n_cached;
      mapped_o    <= req_i && seg_mapped;
      range_err_o <= req_i && seg_range;
      miss_o      <= req_i && n_miss;
      invalid_o   <= req_i && n_inv;
      modify_o    <= req_i && n_mod;
    end
  end
endmodule

// File: rtl/vat_chk.sv
module vat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [31:0] va_i,
  input logic        rsp_o,
  input logic [31:0] pa_o,
  input logic        cached_o,
  input logic        mapped_o,
  input logic        range_err_o,
  input logic        miss_o,
  input logic        invalid_o,
  input logic        modify_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rsp_o == $past(req_i));
  // R1
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_o |-> !(miss_o || invalid_o || modify_o || range_err_o));
  // R9
  one_exception_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({miss_o, invalid_o, modify_o}));
  // R5
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o || invalid_o) |-> (pa_o == 32'h0) && mapped_o);
  // R4
  range_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> !mapped_o);
  // R2
  uncached_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rsp_o && $past(va_i[31:29]) == 3'b101) |->
      (!mapped_o && !cached_o && pa_o == {3'b000, $past(va_i[28:0])}));
endmodule

bind vat_top vat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .va_i        (va_i),
  .rsp_o       (rsp_o),
  .pa_o        (pa_o),
  .cached_o    (cached_o),
  .mapped_o    (mapped_o),
  .range_err_o (range_err_o),
  .miss_o      (miss_o),
  .invalid_o   (invalid_o),
  .modify_o    (modify_o)
);

// File: tb/tb_vat_top.sv
module tb_vat_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        store_i = 1'b0;
  logic [7:0]  asid_i = '0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [19:0] wr_vpn_i = '0;
  logic [2:0]  wr_size_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic        wr_global_i = 1'b0;
  logic [19:0] wr_pfn_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        wr_dirty_i = 1'b0;
  logic        wr_cache_i = 1'b0;
  logic        rsp_o, cached_o, mapped_o, range_err_o, miss_o, invalid_o, modify_o;
  logic [31:0] pa_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vat_top dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [19:0] vpn, input logic [2:0] sz,
                    input logic [7:0] asid, input logic g, input logic [19:0] pfn,
                    input logic v, input logic d, input logic c);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 5'(idx); wr_vpn_i = vpn; wr_size_i = sz;
    wr_asid_i = asid; wr_global_i = g; wr_pfn_i = pfn;
    wr_valid_i = v; wr_dirty_i = d; wr_cache_i = c;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st);
    @(negedge clk_i);
    req_i = 1'b1; va_i = va; asid_i = asid; store_i = st;
    @(negedge clk_i);
    req_i = 1'b0; store_i = 1'b0;
  endtask

  // expect a clean hit/unmapped result
  task automatic expect_ok(input string req, input logic [31:0] pa, input logic c,
                           input logic m);
    chk(req, "rsp", 32'(rsp_o), 32'd1);
    chk(req, "pa", pa_o, pa);
    chk(req, "cached", 32'(cached_o), 32'(c));
    chk(req, "mapped", 32'(mapped_o), 32'(m));
    chk(req, "flags", {29'd0, miss_o, invalid_o, modify_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "rsp after reset", 32'(rsp_o), 32'd0);
    chk("R1", "flags after reset", {28'd0, miss_o, invalid_o, modify_o, range_err_o}, 32'd0);
  endtask

  task automatic t_unmapped();
    look(32'hA000_0040, 8'd0, 1'b0); expect_ok("R2", 32'h40, 1'b0, 1'b0);
    look(32'h8000_0040, 8'd0, 1'b0); expect_ok("R3", 32'h40, 1'b1, 1'b0);
    look(32'hA07F_FFFC, 8'd0, 1'b0);
    chk("R4", "in range", 32'(range_err_o), 32'd0);
    look(32'h8080_0000, 8'd0, 1'b0);
    chk("R4", "out of range", 32'(range_err_o), 32'd1);
    chk("R3", "pa beyond range", pa_o, 32'h0080_0000);
    @(negedge clk_i);
    chk("R1", "rsp drops", 32'(rsp_o), 32'd0);
  endtask

  task automatic t_miss();
    look(32'h1234_5040, 8'd5, 1'b0);
    chk("R5", "miss", 32'(miss_o), 32'd1);
    chk("R5", "pa on miss", pa_o, 32'h0);
    chk("R4", "no range on mapped", 32'(range_err_o), 32'd0);
    look(32'h1234_5040, 8'd5, 1'b0);
    chk("R5", "table untouched", 32'(miss_o), 32'd1);
  endtask

  task automatic t_hit_asid();
    wr(3, 20'h12345, 3'd0, 8'd5, 1'b0, 20'h00400, 1'b1, 1'b1, 1'b1);
    look(32'h1234_5040, 8'd5, 1'b0); expect_ok("R7", 32'h0040_0040, 1'b1, 1'b1);
    look(32'h1234_5040, 8'd6, 1'b0);
    chk("R6", "asid mismatch", 32'(miss_o), 32'd1);
    look(32'h1234_6040, 8'd5, 1'b0);
    chk("R6", "next 4K page", 32'(miss_o), 32'd1);
  endtask

  task automatic t_sizes();
    // 64 KB global page, tag low bits ignored
    wr(4, 20'h2000F, 3'd2, 8'd0, 1'b1, 20'h00123, 1'b1, 1'b1, 1'b0);
    look(32'h2000_ABCD, 8'd9, 1'b0); expect_ok("R6", 32'h0012_ABCD, 1'b0, 1'b1);
    look(32'h2000_FFFF, 8'd1, 1'b0); expect_ok("R7", 32'h0012_FFFF, 1'b0, 1'b1);
    look(32'h2001_0000, 8'd1, 1'b0);
    chk("R6", "past 64K page", 32'(miss_o), 32'd1);
    // 16 MB page in upper mapped segment
    wr(5, 20'hC1000, 3'd6, 8'd0, 1'b1, 20'h03000, 1'b1, 1'b1, 1'b1);
    look(32'hC1AB_CDEF, 8'd0, 1'b0); expect_ok("R7", 32'h03AB_CDEF, 1'b1, 1'b1);
  endtask

  task automatic t_prio();
    wr(9, 20'h30000, 3'd0, 8'd1, 1'b0, 20'h00600, 1'b1, 1'b1, 1'b0);
    wr(7, 20'h30000, 3'd1, 8'd1, 1'b0, 20'h00500, 1'b1, 1'b1, 1'b0);
    look(32'h3000_0010, 8'd1, 1'b0); expect_ok("R8", 32'h0050_0010, 1'b0, 1'b1);
  endtask

  task automatic t_invalid_modify();
    wr(10, 20'h40000, 3'd0, 8'd2, 1'b0, 20'h00700, 1'b0, 1'b1, 1'b1);
    look(32'h4000_0100, 8'd2, 1'b0);
    chk("R9", "invalid", {30'd0, invalid_o, miss_o}, 32'd2);
    chk("R9", "pa on invalid", pa_o, 32'h0);
    wr(11, 20'h50000, 3'd0, 8'd2, 1'b0, 20'h00800, 1'b1, 1'b0, 1'b1);
    look(32'h5000_0020, 8'd2, 1'b1);
    chk("R10", "modify on store", 32'(modify_o), 32'd1);
    chk("R10", "pa on modify", pa_o, 32'h0080_0020);
    look(32'h5000_0020, 8'd2, 1'b0);
    chk("R10", "no modify on load", 32'(modify_o), 32'd0);
    look(32'h1234_5000, 8'd5, 1'b1);
    chk("R10", "store to dirty page", 32'(modify_o), 32'd0);
  endtask

  task automatic t_rewrite();
    // write then lookup on the next cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 5'd3; wr_vpn_i = 20'h12345; wr_size_i = 3'd0;
    wr_asid_i = 8'd5; wr_global_i = 1'b0; wr_pfn_i = 20'h00777;
    wr_valid_i = 1'b1; wr_dirty_i = 1'b1; wr_cache_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    req_i = 1'b1; va_i = 32'h1234_5ABC; asid_i = 8'd5;
    @(negedge clk_i);
    req_i = 1'b0;
    expect_ok("R11", 32'h0077_7ABC, 1'b0, 1'b1);
  endtask

  task automatic t_reset_clears();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    look(32'h1234_5ABC, 8'd5, 1'b0);
    chk("R11", "reset clears table", 32'(miss_o), 32'd1);
    // cleared entries hold tag 0, ID 0, valid 0
    look(32'h0000_0040, 8'd0, 1'b0);
    chk("R11", "cleared entry invalid", 32'(invalid_o), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_unmapped();
    t_miss();
    t_hit_asid();
    t_sizes();
    t_prio();
    t_invalid_modify();
    t_rewrite();
    t_reset_clears();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule